// File: doc/BRIEF.md
# Link Alarm and Control-Byte Status Logic

This block sits beside the framer of a serial radio link and handles the maintenance bits of the link's alarm control byte. In one direction it takes the control byte the framer pulls out of the received stream, keeps the alarm bits from the latest valid copy, and presents them as remote alarm flags. In the other direction it builds the alarm bits for the byte the framer sends: the local loss flags, and the SDI and reset bits. Each of those two bits comes from a request pin or from a small management register.

A run-time role input selects master or slave. The reset handshake changes with the role. A master sends a reset request and receives an acknowledge, and a slave does the reverse. So the request and acknowledge pins swap meaning whenever the role changes. A single summary alarm combines everything that indicates trouble: local, received, and register-driven.

All logic runs on one management clock with a synchronous active-high reset. While reset is held, every registered output stays at zero and does not follow its inputs.

Top module: `lnk_alarm_stat`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`loc_*`, `rem_*`, `rst_req_out`, `rst_ack_out`, `alarm_sum`, `tx_cw`, `cfg_rd_data`) reads zero after that edge, whatever the other inputs do. The first edge with `rst` low updates the outputs again.
- R2: `loc_los` and `loc_lof` show `los_in` and `lof_in` one clock later. `loc_rai` is high exactly when `loc_los` or `loc_lof` is high.
- R3: The control-byte bit positions are reset = bit 0, RAI = bit 1, SDI = bit 2, LOS = bit 3 and LOF = bit 4. On an edge where `rx_cw_vld` is high, `rem_lof`, `rem_los`, `rem_sdi` and `rem_rai` take bits 4, 3, 2 and 1 of `rx_cw`. On any other edge they keep their values.
- R4: The received reset bit is held in the same way as in R3. It drives `rst_ack_out` when `role_master` is 1 and `rst_req_out` when `role_master` is 0, and the other pin is driven to 0. A change of role moves the held bit to the other pin at the next edge, with no new strobe needed.
- R5: One clock after an edge, `tx_cw` bit 2 equals `sdi_req_in` OR the register SDI bit, both sampled at that edge.
- R6: One clock after an edge, `tx_cw` bit 0 equals the register reset bit OR the reset pin selected by the role. In master role that pin is `rst_req_in`; in slave role it is `rst_ack_in`. All values are sampled at that edge.
- R7: One clock after an edge, `tx_cw` bits 3 and 4 carry `los_in` and `lof_in`, and bit 1 carries their OR. Bits 5 and above are 0.
- R8: `alarm_sum` is registered. It is high one clock after an edge at which any of the following was set: either register bit, any held received bit (LOF, LOS, SDI, RAI, reset), or `loc_los`, `loc_lof` or `loc_rai`.
- R9: When `cfg_wr_en` is high at an edge, `cfg_rd_data` takes `cfg_wr_data`; bit 1 is SDI and bit 0 is reset. Otherwise `cfg_rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 selects master role, 0 selects slave role |
| los_in | input | 1 | Local loss-of-signal flag |
| lof_in | input | 1 | Local loss-of-frame flag |
| rx_cw | input | CW_W | Received alarm control byte |
| rx_cw_vld | input | 1 | Strobe marking `rx_cw` as valid |
| rst_req_in | input | 1 | Reset request pin, used in master role |
| rst_ack_in | input | 1 | Reset acknowledge pin, used in slave role |
| sdi_req_in | input | 1 | SDI request pin |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_wr_data | input | 2 | Register write data: bit 1 SDI, bit 0 reset |
| cfg_rd_data | output | 2 | Register contents |
| loc_los | output | 1 | Local loss of signal |
| loc_lof | output | 1 | Local loss of frame |
| loc_rai | output | 1 | Local remote-alarm indication |
| rem_los | output | 1 | Held received LOS bit |
| rem_lof | output | 1 | Held received LOF bit |
| rem_rai | output | 1 | Held received RAI bit |
| rem_sdi | output | 1 | Held received SDI bit |
| rst_req_out | output | 1 | Received reset bit, slave role |
| rst_ack_out | output | 1 | Received reset bit, master role |
| alarm_sum | output | 1 | Summary alarm |
| tx_cw | output | CW_W | Alarm control byte to transmit |

## Verification
The hardest case to reach is a role change that falls between two valid strobes while a held reset bit is set. Only then does the bit have to move from one output pin to the other with no new byte arriving. The stimulus reaches it in a phase that flips `role_master` every few cycles and keeps `rx_cw_vld` sparse. A second hard case is reset asserted in the middle of traffic, with strobes, writes and requests still toggling. Here the outputs must stay at zero and then resume from a clean state, which a burst of reset in the middle of the random phase brings about.

// File: rtl/lnk_alarm_pkg.sv
package lnk_alarm_pkg;
   // number of alarm bits carried at the bottom of the control byte
   localparam int ALM_W = 5;

   // packed so that the field order matches the control-byte bit positions
   typedef struct packed {
      logic lof;   // bit 4
      logic los;   // bit 3
      logic sdi;   // bit 2
      logic rai;   // bit 1
      logic rst;   // bit 0
   } alm_bits_t;

   typedef struct packed {
      logic sdi;   // bit 1
      logic rst;   // bit 0
   } cfg_bits_t;

   localparam int CFG_W = $bits(cfg_bits_t);
endpackage

// File: rtl/lnk_alarm_cfg.sv
module lnk_alarm_cfg
   import lnk_alarm_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      wr_en,
   input  cfg_bits_t wr_data,
   output cfg_bits_t cfg_q
);
   always_ff @(posedge clk) begin
      if (rst)        cfg_q <= '0;
      else if (wr_en) cfg_q <= wr_data;
   end
endmodule

// File: rtl/lnk_alarm_loc.sv
module lnk_alarm_loc (
   input  logic clk,
   input  logic rst,
   input  logic los_in,
   input  logic lof_in,
   output logic los_q,
   output logic lof_q,
   output logic rai_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         los_q <= 1'b0;
         lof_q <= 1'b0;
         rai_q <= 1'b0;
      end else begin
         los_q <= los_in;
         lof_q <= lof_in;
         rai_q <= los_in | lof_in;
      end
   end
endmodule

// File: rtl/lnk_alarm_rx.sv
module lnk_alarm_rx
   import lnk_alarm_pkg::*;
#(
   parameter int CW_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            is_master,
   input  logic [CW_W-1:0] rx_cw,
   input  logic            rx_vld,
   output alm_bits_t       rem_q,
   output logic            rst_req_q,
   output logic            rst_ack_q
);
   alm_bits_t rem_nxt;

   generate
      if (CW_W > ALM_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^rx_cw[CW_W-1:ALM_W];
      end
   endgenerate

   always_comb begin
      rem_nxt = rx_vld ? alm_bits_t'(rx_cw[ALM_W-1:0]) : rem_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q     <= '0;
         rst_req_q <= 1'b0;
         rst_ack_q <= 1'b0;
      end else begin
         rem_q     <= rem_nxt;
         rst_req_q <= ~is_master & rem_nxt.rst;
         rst_ack_q <=  is_master & rem_nxt.rst;
      end
   end
endmodule

// File: rtl/lnk_alarm_tx.sv
module lnk_alarm_tx
   import lnk_alarm_pkg::*;
#(
   parameter int CW_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            is_master,
   input  logic            los_in,
   input  logic            lof_in,
   input  logic            rst_req_in,
   input  logic            rst_ack_in,
   input  logic            sdi_req_in,
   input  cfg_bits_t       cfg_q,
   output logic [CW_W-1:0] tx_cw
);
   alm_bits_t       alm;
   logic [CW_W-1:0] cw_nxt;

   always_comb begin
      alm.rst = (is_master ? rst_req_in : rst_ack_in) | cfg_q.rst;
      alm.sdi = sdi_req_in | cfg_q.sdi;
      alm.los = los_in;
      alm.lof = lof_in;
      alm.rai = los_in | lof_in;
      cw_nxt  = '0;
      cw_nxt[ALM_W-1:0] = alm;
   end

   always_ff @(posedge clk) begin
      if (rst) tx_cw <= '0;
      else     tx_cw <= cw_nxt;
   end
endmodule

// File: rtl/lnk_alarm_stat.sv
module lnk_alarm_stat
   import lnk_alarm_pkg::*;
#(
   parameter int CW_W           = 8,
   parameter int MASTER_CAPABLE = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            role_master,
   input  logic            los_in,
   input  logic            lof_in,
   input  logic [CW_W-1:0] rx_cw,
   input  logic            rx_cw_vld,
   input  logic            rst_req_in,
   input  logic            rst_ack_in,
   input  logic            sdi_req_in,
   input  logic            cfg_wr_en,
   input  logic [1:0]      cfg_wr_data,
   output logic [1:0]      cfg_rd_data,
   output logic            loc_los,
   output logic            loc_lof,
   output logic            loc_rai,
   output logic            rem_los,
   output logic            rem_lof,
   output logic            rem_rai,
   output logic            rem_sdi,
   output logic            rst_req_out,
   output logic            rst_ack_out,
   output logic            alarm_sum,
   output logic [CW_W-1:0] tx_cw
);
   logic      role_eff;
   cfg_bits_t cfg_q;
   alm_bits_t rem_q;

   generate
      if (CW_W < ALM_W) begin : g_bad_width
         $error("lnk_alarm_stat: CW_W must hold all alarm bits");
      end
      if (MASTER_CAPABLE != 0 && MASTER_CAPABLE != 1) begin : g_bad_opt
         $error("lnk_alarm_stat: MASTER_CAPABLE must be 0 or 1");
      end
      if (MASTER_CAPABLE == 1) begin : g_role_pin
         assign role_eff = role_master;
      end else begin : g_role_slave
         logic unused_role;
         assign unused_role = role_master;
         assign role_eff    = 1'b0;
      end
   endgenerate

   lnk_alarm_cfg u_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_bits_t'(cfg_wr_data)),
      .cfg_q   (cfg_q)
   );

   lnk_alarm_loc u_loc (
      .clk    (clk),
      .rst    (rst),
      .los_in (los_in),
      .lof_in (lof_in),
      .los_q  (loc_los),
      .lof_q  (loc_lof),
      .rai_q  (loc_rai)
   );

   lnk_alarm_rx #(.CW_W(CW_W)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .is_master (role_eff),
      .rx_cw     (rx_cw),
      .rx_vld    (rx_cw_vld),
      .rem_q     (rem_q),
      .rst_req_q (rst_req_out),
      .rst_ack_q (rst_ack_out)
   );

   lnk_alarm_tx #(.CW_W(CW_W)) u_tx (
      .clk        (clk),
      .rst        (rst),
      .is_master  (role_eff),
      .los_in     (los_in),
      .lof_in     (lof_in),
      .rst_req_in (rst_req_in),
      .rst_ack_in (rst_ack_in),
      .sdi_req_in (sdi_req_in),
      .cfg_q      (cfg_q),
      .tx_cw      (tx_cw)
   );

   assign cfg_rd_data = cfg_q;
   assign rem_los     = rem_q.los;
   assign rem_lof     = rem_q.lof;
   assign rem_rai     = rem_q.rai;
   assign rem_sdi     = rem_q.sdi;

   always_ff @(posedge clk) begin
      if (rst) alarm_sum <= 1'b0;
      else     alarm_sum <= (|cfg_q) | (|rem_q) | loc_los | loc_lof | loc_rai;
   end
endmodule

// File: rtl/lnk_alarm_chk.sv
module lnk_alarm_chk (
   input logic       clk,
   input logic       rst,
   input logic       role_eff,
   input logic       los_in,
   input logic       lof_in,
   input logic [4:0] rx_alm,
   input logic       rx_cw_vld,
   input logic       rst_req_in,
   input logic       rst_ack_in,
   input logic       sdi_req_in,
   input logic       cfg_wr_en,
   input logic [1:0] cfg_wr_data,
   input logic [1:0] cfg_rd_data,
   input logic       loc_los,
   input logic       loc_lof,
   input logic       loc_rai,
   input logic       rem_los,
   input logic       rem_lof,
   input logic       rem_rai,
   input logic       rem_sdi,
   input logic       rst_req_out,
   input logic       rst_ack_out,
   input logic       alarm_sum,
   input logic [4:0] tx_alm
);
   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      rst |=> (tx_alm == 5'd0 && !alarm_sum && cfg_rd_data == 2'd0 &&
               !rst_req_out && !rst_ack_out && !rem_sdi && !loc_rai));

   // R2
   loc_rai_chk: assert property (@(posedge clk) disable iff (rst)
      loc_rai == (loc_los | loc_lof));

   // R3
   rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_cw_vld |=> $stable({rem_lof, rem_los, rem_sdi, rem_rai}));

   // R3
   rem_cap_chk: assert property (@(posedge clk) disable iff (rst)
      rx_cw_vld |=> {rem_lof, rem_los, rem_sdi, rem_rai} == $past(rx_alm[4:1]));

   // R4
   rst_pin_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rst_req_out, rst_ack_out}));

   // R4
   rst_cap_chk: assert property (@(posedge clk) disable iff (rst)
      rx_cw_vld |=> (rst_req_out | rst_ack_out) == $past(rx_alm[0]));

   // R5
   tx_sdi_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> tx_alm[2] == ($past(sdi_req_in) | $past(cfg_rd_data[1])));

   // R6
   tx_rst_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> tx_alm[0] == ($past(role_eff ? rst_req_in : rst_ack_in) |
                             $past(cfg_rd_data[0])));

   // R7
   tx_loc_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (tx_alm[3] == $past(los_in) && tx_alm[4] == $past(lof_in) &&
                tx_alm[1] == $past(los_in | lof_in)));

   // R8
   sum_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> alarm_sum == $past((|cfg_rd_data) | rem_los | rem_lof | rem_rai |
                                  rem_sdi | rst_req_out | rst_ack_out |
                                  loc_los | loc_lof | loc_rai));

   // R9
   cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));
endmodule

bind lnk_alarm_stat lnk_alarm_chk chk_i (
   .clk         (clk),
   .rst         (rst),
   .role_eff    (role_eff),
   .los_in      (los_in),
   .lof_in      (lof_in),
   .rx_alm      (rx_cw[4:0]),
   .rx_cw_vld   (rx_cw_vld),
   .rst_req_in  (rst_req_in),
   .rst_ack_in  (rst_ack_in),
   .sdi_req_in  (sdi_req_in),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_wr_data (cfg_wr_data),
   .cfg_rd_data (cfg_rd_data),
   .loc_los     (loc_los),
   .loc_lof     (loc_lof),
   .loc_rai     (loc_rai),
   .rem_los     (rem_los),
   .rem_lof     (rem_lof),
   .rem_rai     (rem_rai),
   .rem_sdi     (rem_sdi),
   .rst_req_out (rst_req_out),
   .rst_ack_out (rst_ack_out),
   .alarm_sum   (alarm_sum),
   .tx_alm      (tx_cw[4:0])
);

// File: tb/lnk_alarm_stat_tb_top.sv
module lnk_alarm_stat_tb_top;
   localparam int CW_W = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            role_master = 1'b1;
   logic            los_in = 1'b0, lof_in = 1'b0;
   logic [CW_W-1:0] rx_cw = '0;
   logic            rx_cw_vld = 1'b0;
   logic            rst_req_in = 1'b0, rst_ack_in = 1'b0, sdi_req_in = 1'b0;
   logic            cfg_wr_en = 1'b0;
   logic [1:0]      cfg_wr_data = 2'd0;
   logic [1:0]      cfg_rd_data;
   logic            loc_los, loc_lof, loc_rai;
   logic            rem_los, rem_lof, rem_rai, rem_sdi;
   logic            rst_req_out, rst_ack_out, alarm_sum;
   logic [CW_W-1:0] tx_cw;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state
   logic [1:0]      m_cfg = '0;
   logic [4:0]      m_rx  = '0;
   logic            m_req = 0, m_ack = 0, m_llos = 0, m_llof = 0, m_lrai = 0, m_sum = 0;
   logic [CW_W-1:0] m_tx  = '0;

   always #5 clk = ~clk;

   lnk_alarm_stat #(.CW_W(CW_W), .MASTER_CAPABLE(1)) dut_i (
      .clk(clk), .rst(rst), .role_master(role_master),
      .los_in(los_in), .lof_in(lof_in), .rx_cw(rx_cw), .rx_cw_vld(rx_cw_vld),
      .rst_req_in(rst_req_in), .rst_ack_in(rst_ack_in), .sdi_req_in(sdi_req_in),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .loc_los(loc_los), .loc_lof(loc_lof), .loc_rai(loc_rai),
      .rem_los(rem_los), .rem_lof(rem_lof), .rem_rai(rem_rai), .rem_sdi(rem_sdi),
      .rst_req_out(rst_req_out), .rst_ack_out(rst_ack_out),
      .alarm_sum(alarm_sum), .tx_cw(tx_cw)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural next state from the inputs present at this edge
   task automatic model_edge();
      logic [4:0] nrx;
      logic       pin;
      if (rst) begin
         m_cfg = '0; m_rx = '0; m_req = 0; m_ack = 0;
         m_llos = 0; m_llof = 0; m_lrai = 0; m_sum = 0; m_tx = '0;
      end else begin
         nrx   = rx_cw_vld ? rx_cw[4:0] : m_rx;
         m_sum = (m_cfg != 0) || (m_rx != 0) || m_llos || m_llof || m_lrai;
         pin   = role_master ? rst_req_in : rst_ack_in;
         m_tx  = '0;
         m_tx[0] = pin | m_cfg[0];
         m_tx[1] = los_in | lof_in;
         m_tx[2] = sdi_req_in | m_cfg[1];
         m_tx[3] = los_in;
         m_tx[4] = lof_in;
         m_req = !role_master && nrx[0];
         m_ack =  role_master && nrx[0];
         m_rx  = nrx;
         if (cfg_wr_en) m_cfg = cfg_wr_data;
         m_llos = los_in; m_llof = lof_in; m_lrai = los_in | lof_in;
      end
   endtask

   task automatic compare_all();
      if (rst) begin
         chk("R1 outputs in reset",
             {cfg_rd_data, loc_los, loc_lof, loc_rai, rem_los, rem_lof, rem_rai, rem_sdi,
              rst_req_out, rst_ack_out, alarm_sum, (tx_cw != 0)}, 16'd0);
         return;
      end
      chk("R2 local flags", {loc_los, loc_lof, loc_rai}, {m_llos, m_llof, m_lrai});
      chk("R3 remote flags", {rem_lof, rem_los, rem_sdi, rem_rai}, m_rx[4:1]);
      chk("R4 reset pins", {rst_req_out, rst_ack_out}, {m_req, m_ack});
      chk("R5 tx sdi", tx_cw[2], m_tx[2]);
      chk("R6 tx reset", tx_cw[0], m_tx[0]);
      chk("R7 tx local and pad", {tx_cw[CW_W-1:5], tx_cw[4:3], tx_cw[1]},
          {m_tx[CW_W-1:5], m_tx[4:3], m_tx[1]});
      chk("R8 alarm_sum", alarm_sum, m_sum);
      chk("R9 cfg readback", cfg_rd_data, m_cfg);
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   // vld_pct: strobe rate; act_pct: rate of alarm-ish inputs
   task automatic rand_inputs(input int vld_pct, input int act_pct);
      los_in      = ($urandom % 100) < act_pct;
      lof_in      = ($urandom % 100) < act_pct;
      rx_cw_vld   = ($urandom % 100) < vld_pct;
      rx_cw       = CW_W'($urandom);
      rst_req_in  = ($urandom % 100) < act_pct;
      rst_ack_in  = ($urandom % 100) < act_pct;
      sdi_req_in  = ($urandom % 100) < act_pct;
      cfg_wr_en   = ($urandom % 100) < 10;
      cfg_wr_data = 2'($urandom);
   endtask

   task automatic quiet_inputs();
      los_in = 0; lof_in = 0; rx_cw_vld = 0; rx_cw = '0;
      rst_req_in = 0; rst_ack_in = 0; sdi_req_in = 0; cfg_wr_en = 0; cfg_wr_data = '0;
   endtask

   initial begin
      @(negedge clk);
      // R1: reset held with busy inputs
      for (int i = 0; i < 6; i++) begin rand_inputs(50, 50); step(); end
      rst = 1'b0;
      quiet_inputs();
      for (int i = 0; i < 3; i++) step();

      // R4 directed: capture reset bit as master, then flip role without strobe
      rx_cw = 8'h01; rx_cw_vld = 1; step();
      rx_cw_vld = 0; role_master = 0; step();
      chk("R4 swap on role change", {rst_req_out, rst_ack_out}, 2'b10);
      role_master = 1; step();
      chk("R4 swap back", {rst_req_out, rst_ack_out}, 2'b01);

      // R3 directed: bits 4..1 land on LOF, LOS, SDI, RAI; ignored without strobe
      rx_cw = 8'h1A; rx_cw_vld = 1; step();
      chk("R3 capture 0x1A", {rem_lof, rem_los, rem_sdi, rem_rai}, 4'b1101);
      rx_cw = 8'h00; rx_cw_vld = 0; step();
      chk("R3 hold without strobe", {rem_lof, rem_los, rem_sdi, rem_rai}, 4'b1101);

      // R9/R6 directed: register reset bit alone drives tx bit 0 one edge later
      quiet_inputs(); rx_cw_vld = 1; step();
      cfg_wr_en = 1; cfg_wr_data = 2'b01; step();
      cfg_wr_en = 0; step();
      chk("R6 register reset bit", tx_cw[0], 1'b1);
      chk("R8 sum from register", alarm_sum, 1'b1);
      cfg_wr_en = 1; cfg_wr_data = 2'b00; step(); cfg_wr_en = 0; step(); step();
      chk("R8 sum clear", alarm_sum, 1'b0);

      // master random traffic
      role_master = 1;
      for (int i = 0; i < 600; i++) begin rand_inputs(25, 30); step(); end
      // slave random traffic
      role_master = 0;
      for (int i = 0; i < 600; i++) begin rand_inputs(25, 30); step(); end
      // role flips with sparse strobes
      for (int i = 0; i < 600; i++) begin
         rand_inputs(8, 40);
         if (i % 3 == 0) role_master = ~role_master;
         step();
      end
      // R1: reset in the middle of traffic, then resume
      rst = 1'b1;
      for (int i = 0; i < 12; i++) begin rand_inputs(60, 60); step(); end
      rst = 1'b0;
      for (int i = 0; i < 400; i++) begin rand_inputs(25, 30); role_master = i[4]; step(); end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule